// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block generates the timing reference for a two-output pulse-width modulator. The input clock passes through two prescalers in series. The first divides by a power of two. The second divides by twice its code, and its code zero means divide by one. Each pulse out of the second stage is one counter tick. On every tick a 16-bit counter steps according to the selected mode: up, down, up-then-down (triangle), or frozen. The number of ticks in a cycle is set by a period register, which holds that count minus one.

Downstream compare and action logic receives four things from the block: the counter value, the count direction, and two one-cycle strobes. One strobe marks the counter arriving at zero and the other marks it arriving at the period value. Software programs a control word and the period through a small 16-bit write port, and reads them back, together with the live counter, through a combinational read port. A debug-halt input stops the whole chain unless the control word selects free running.

The counter core is a two-state machine. Its states are PH_RISE (counting toward the period) and PH_FALL (counting toward zero). Up mode forces PH_RISE and down mode forces PH_FALL. In triangle mode the transition PH_RISE to PH_FALL is taken on a tick at or above the period value, and the transition PH_FALL to PH_RISE is taken on a tick at zero. Freeze mode takes no transition.

Top module: `pwm_timebase`

## Requirements
- R1: Control bits [1:0] select the counting mode: 0 counts up, 1 counts down, 2 counts up then down, 3 freezes. In freeze mode the counter and the direction output hold their values.
- R2: Control bits [12:10] hold code c1. The first prescaler divides the clock by 2^c1, from 1 up to 128.
- R3: Control bits [9:7] hold code c2. The second prescaler divides by 1 when c2 is 0 and by 2*c2 otherwise. One tick occurs every 2^c1 times that ratio clock cycles.
- R4: In up mode each tick advances the counter by one. A tick at or above the period value P wraps the counter to 0, so a cycle lasts P+1 ticks. With P=0xFFFF the cycle is 65536 ticks.
- R5: In down mode each tick lowers the counter by one. A tick at 0 reloads P.
- R6: In triangle mode the counter rises to P, then falls to 0, then rises again. dir_up_o is 1 while rising and 0 while falling. It is set to 1 by any tick in up mode and to 0 by any tick in down mode.
- R7: zero_o (prd_o) is high for exactly the one clock cycle that follows a tick which leaves the counter at 0 (at P). Both are high together when P is 0. Neither is raised in freeze mode.
- R8: While dbg_halt is 1 and control bit 15 is 0, the prescalers and the counter stop. When bit 15 is 1 (field [15:14] equal to 2 or 3), they keep running.
- R9: Reset clears the counter, both prescalers, the strobes and the control word, sets dir_up_o to 1, and loads the period with RESET_PERIOD (999).
- R10: rd_addr 0 returns the control word, with bits 13 and [6:2] reading 0. Address 1 returns the period, address 2 the counter, and address 3 zero. wr_addr 0 and 1 write the control word and the period. Writes to addresses 2 and 3 are ignored.
- R11: A new control word takes effect on the first tick after the write edge. A tick on the write edge itself still uses the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 period) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| dbg_halt | input | 1 | Debug halt request |
| cnt_o | output | 16 | Counter value |
| zero_o | output | 1 | Counter reached zero strobe |
| prd_o | output | 1 | Counter reached period strobe |
| dir_up_o | output | 1 | 1 while counting up |

## Verification
A register write can land on the same clock edge as a tick. On that edge the tick must still use the old mode and the old dividers, and the new word applies from the next tick. Random writes with small divide ratios make this collision frequent. A reference model inside the bench judges every cycle: it advances its own counter with the pre-write control word and only then applies the write. The second coincidence is the zero and period strobes firing together. It is forced with a period of zero and checked directly.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    // Counting modes encoded in control bits [1:0]
    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_HOLD = 2'd3
    } mode_e;

    // Counter machine states
    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    // Control word field positions
    localparam int MODE_LSB  = 0;
    localparam int DIV2_LSB  = 7;
    localparam int DIV1_LSB  = 10;
    localparam int FREE_BIT  = 15;
    localparam logic [15:0] CTRL_MASK = 16'hDF83;

    // Register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_PRD  = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs #(
    parameter int          DATA_W       = 16,
    parameter logic [15:0] RESET_PERIOD = 16'd999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] prd_q
);
    import tbase_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            prd_q  <= DATA_W'(RESET_PERIOD);
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  ctrl_q <= wr_data & DATA_W'(CTRL_MASK);
                A_PRD:   prd_q  <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tbase_divstage.sv
module tbase_divstage #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic         pulse
);
    logic [W-1:0] q;

    // >= keeps the stage safe when the limit drops below the running count
    assign pulse = en && (q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= pulse ? '0 : q + W'(1);
    end

endmodule

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
    parameter int DIV1_BITS = 3,
    parameter int DIV2_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [DIV1_BITS-1:0] div1_code,
    input  logic [DIV2_BITS-1:0] div2_code,
    output logic                 tick
);
    localparam int S1_W = (1 << DIV1_BITS) - 1;
    localparam int S2_W = DIV2_BITS + 1;

    logic [S1_W-1:0] lim1;
    logic [S2_W-1:0] lim2;
    logic            p1;

    // ratio 2^code, limit = ratio-1 (wraps to all ones for the top code)
    assign lim1 = (S1_W'(1) << div1_code) - S1_W'(1);
    // ratio 1 for code 0, else 2*code
    assign lim2 = (div2_code == '0) ? '0 : ({1'b0, div2_code} << 1) - S2_W'(1);

    tbase_divstage #(.W(S1_W)) u_st1 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .lim   (lim1),
        .pulse (p1)
    );

    tbase_divstage #(.W(S2_W)) u_st2 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (p1),
        .lim   (lim2),
        .pulse (tick)
    );

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tbase_pkg::mode_e mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             zero_stb,
    output logic             prd_stb
);
    import tbase_pkg::*;

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             moved;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_RISE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        moved = 1'b0;
        if (tick) begin
            unique case (mode)
                MODE_UP: begin
                    moved = 1'b1;
                    ph_d  = PH_RISE;
                    cnt_d = (cnt_q >= period) ? '0 : cnt_q + CNT_W'(1);
                end
                MODE_DOWN: begin
                    moved = 1'b1;
                    ph_d  = PH_FALL;
                    cnt_d = (cnt_q == '0) ? period : cnt_q - CNT_W'(1);
                end
                MODE_UPDN: begin
                    moved = 1'b1;
                    unique case (ph_q)
                        PH_RISE: begin
                            if (cnt_q >= period) begin
                                ph_d  = PH_FALL;
                                cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
                            end else begin
                                cnt_d = cnt_q + CNT_W'(1);
                            end
                        end
                        PH_FALL: begin
                            if (cnt_q == '0) begin
                                ph_d  = PH_RISE;
                                cnt_d = (period == '0) ? '0 : CNT_W'(1);
                            end else begin
                                cnt_d = cnt_q - CNT_W'(1);
                            end
                        end
                        default: ;
                    endcase
                end
                MODE_HOLD: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_stb <= 1'b0;
            prd_stb  <= 1'b0;
        end else begin
            zero_stb <= moved && (cnt_d == '0);
            prd_stb  <= moved && (cnt_d == period);
        end
    end

    assign cnt    = cnt_q;
    assign dir_up = (ph_q == PH_RISE);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int          CNT_W        = 16,
    parameter int          DIV1_BITS    = 3,
    parameter int          DIV2_BITS    = 3,
    parameter logic [15:0] RESET_PERIOD = 16'd999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             dbg_halt,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             prd_o,
    output logic             dir_up_o
);
    import tbase_pkg::*;

    logic [CNT_W-1:0] ctrl_q;
    logic [CNT_W-1:0] prd_q;
    logic             run;
    logic             tick;
    mode_e            mode;

    tbase_regs #(.DATA_W(CNT_W), .RESET_PERIOD(RESET_PERIOD)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .prd_q   (prd_q)
    );

    assign run  = !dbg_halt || ctrl_q[FREE_BIT];
    assign mode = mode_e'(ctrl_q[MODE_LSB +: 2]);

    tbase_prescale #(.DIV1_BITS(DIV1_BITS), .DIV2_BITS(DIV2_BITS)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div1_code (ctrl_q[DIV1_LSB +: DIV1_BITS]),
        .div2_code (ctrl_q[DIV2_LSB +: DIV2_BITS]),
        .tick      (tick)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .period   (prd_q),
        .cnt      (cnt_o),
        .dir_up   (dir_up_o),
        .zero_stb (zero_o),
        .prd_stb  (prd_o)
    );

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl_q;
            A_PRD:   rd_data = prd_q;
            A_CNT:   rd_data = cnt_o;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_halt,
    input logic [CNT_W-1:0] ctrl,
    input logic [CNT_W-1:0] period,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             dir_up,
    input logic             zero_stb,
    input logic             prd_stb
);
    a_r1_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1:0] == 2'd3) |=> ($stable(cnt) && $stable(dir_up)));

    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[1:0] == 2'd0) |=> (cnt == CNT_W'($past(cnt) + 1) || cnt == '0));

    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[1:0] == 2'd1) |=> (cnt == CNT_W'($past(cnt) - 1) || cnt == $past(period)));

    a_r6_dir_up_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[1:0] == 2'd0) |=> dir_up);

    a_r7_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
        zero_stb |-> (cnt == '0));

    a_r7_prd_value: assert property (@(posedge clk) disable iff (!rst_n)
        prd_stb |-> (cnt == $past(period)));

    a_r7_no_strobe_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1:0] == 2'd3) |=> (!zero_stb && !prd_stb));

    a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !ctrl[15]) |=> $stable(cnt));

endmodule

bind pwm_timebase tbase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_halt (dbg_halt),
    .ctrl     (ctrl_q),
    .period   (prd_q),
    .tick     (tick),
    .cnt      (cnt_o),
    .dir_up   (dir_up_o),
    .zero_stb (zero_o),
    .prd_stb  (prd_o)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic [15:0] cnt_o;
    logic        zero_o, prd_o, dir_up_o;

    int n_run = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    pwm_timebase u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .cnt_o(cnt_o), .zero_o(zero_o),
        .prd_o(prd_o), .dir_up_o(dir_up_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model (from the requirements) ----------
    int m_c1, m_c2, m_cnt, m_prd;
    bit m_up, m_z, m_p;
    logic [15:0] m_ctrl;

    function automatic int ratio1(logic [15:0] c); return 1 << c[12:10]; endfunction
    function automatic int ratio2(logic [15:0] c);
        return (c[9:7] == 0) ? 1 : 2 * int'(c[9:7]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_cnt = 0; m_prd = 999;
            m_up = 1; m_z = 0; m_p = 0; m_ctrl = '0;
        end else begin
            bit tk, p1, mv;
            int nx;
            tk = 0; mv = 0; nx = m_cnt;
            if (!dbg_halt || m_ctrl[15]) begin
                p1 = (m_c1 >= ratio1(m_ctrl) - 1);
                m_c1 = p1 ? 0 : m_c1 + 1;
                if (p1) begin
                    tk = (m_c2 >= ratio2(m_ctrl) - 1);
                    m_c2 = tk ? 0 : m_c2 + 1;
                end
            end
            if (tk) begin
                case (m_ctrl[1:0])
                    2'd0: begin mv = 1; m_up = 1; nx = (m_cnt >= m_prd) ? 0 : m_cnt + 1; end
                    2'd1: begin mv = 1; m_up = 0; nx = (m_cnt == 0) ? m_prd : m_cnt - 1; end
                    2'd2: begin
                        mv = 1;
                        if (m_up) begin
                            if (m_cnt >= m_prd) begin m_up = 0; nx = (m_cnt == 0) ? 0 : m_cnt - 1; end
                            else nx = m_cnt + 1;
                        end else begin
                            if (m_cnt == 0) begin m_up = 1; nx = (m_prd == 0) ? 0 : 1; end
                            else nx = m_cnt - 1;
                        end
                    end
                    default: ;
                endcase
            end
            m_z = mv && (nx == 0);
            m_p = mv && (nx == m_prd);
            m_cnt = nx;
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data & 16'hDF83;
            if (wr_en && wr_addr == 2'd1) m_prd = int'(wr_data);
        end
    end

    // per-cycle comparison against the model (R1..R8, R11)
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R4/R5/R6/R11 counter", cnt_o, m_cnt[15:0]);
            check("R6 direction", dir_up_o, m_up);
            check("R7 zero strobe", zero_o, m_z);
            check("R7 period strobe", prd_o, m_p);
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // measure clock cycles between two counter changes (R2, R3)
    task automatic measure(logic [15:0] c, int exp, string req);
        logic [15:0] prev;
        int n;
        wr(2'd0, c);
        repeat (3 * exp + 4) @(negedge clk);
        prev = cnt_o;
        while (cnt_o == prev) @(negedge clk);
        prev = cnt_o; n = 0;
        while (cnt_o == prev) begin @(negedge clk); n++; end
        check(req, n, exp);
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d, held;
        void'($urandom(32'd4217));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 counter", cnt_o, 16'd0);
        check("R9 zero strobe", zero_o, 1'b0);
        check("R9 period strobe", prd_o, 1'b0);
        check("R9 direction", dir_up_o, 1'b1);
        rd(2'd0, d); check("R9 control", d, 16'd0);
        rd(2'd1, d); check("R9 period", d, 16'd999);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R10: masked control readback
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); check("R10 control mask", d, 16'hDF83);
        // R1 + R10: freeze, then writes to read-only addresses
        wr(2'd0, 16'h0003);
        held = cnt_o;
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'hBEEF);
        rd(2'd2, d); check("R10 counter ignores write", d, held);
        rd(2'd3, d); check("R10 addr3 reads zero", d, 16'd0);
        rd(2'd1, d); check("R10 period kept", d, 16'd999);
        repeat (20) @(negedge clk);
        check("R1 freeze holds", cnt_o, held);

        // R2/R3: tick spacing
        wr(2'd1, 16'hFFFF);
        measure(16'h0000, 1,  "R3 div 1x1");
        measure(16'h0C00, 8,  "R2 div 8x1");
        measure(16'h0080, 2,  "R3 div 1x2");
        measure(16'h0980, 24, "R2/R3 div 4x6");

        // R4: full 65536-tick wrap
        wr(2'd0, 16'h0000);
        while (cnt_o != 16'hFFFF) @(negedge clk);
        @(negedge clk);
        check("R4 wrap from FFFF", cnt_o, 16'd0);
        check("R7 zero after wrap", zero_o, 1'b1);

        // R7: both strobes with period 0
        wr(2'd1, 16'd0);
        repeat (4) @(negedge clk);
        check("R7 both strobes", {zero_o, prd_o}, 2'b11);

        // R8: halt without and with free run
        wr(2'd1, 16'd50);
        wr(2'd0, 16'h0000);
        dbg_halt = 1'b1;
        repeat (2) @(negedge clk);
        held = cnt_o;
        repeat (10) @(negedge clk);
        check("R8 halted", cnt_o, held);
        wr(2'd0, 16'h8000);
        repeat (3) @(negedge clk);
        check("R8 free run moves", (cnt_o != held), 1'b1);
        dbg_halt = 1'b0;

        // random phase, judged by the model every cycle
        for (int s = 0; s < 60; s++) begin
            logic [15:0] c;
            c = '0;
            c[1:0]   = 2'($urandom % 4);
            c[12:10] = 3'($urandom % 3);
            c[9:7]   = 3'($urandom % 3);
            c[15]    = 1'($urandom % 2);
            if ($urandom % 3 == 0) wr(2'd1, 16'($urandom % 12));
            else if ($urandom % 4 == 0) wr(2'd1, 16'($urandom % 200));
            wr(2'd0, c);
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                dbg_halt = ($urandom % 8 == 0);
            end
        end
        dbg_halt = 1'b0;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule